// File: doc/BRIEF.md
# Segmented Microsequencer With Keyed Dispatch

This block is a byte-wide microcode sequencer that reads its program from a code ROM with a 10-bit address space. Several cooperative routines share the sequencer. Each routine is divided into segments. One instruction records which segment should run next, and a separate yield instruction gives up control. On a yield, a dispatch table produces the next program counter. The table is keyed by the external routine number, the recorded segment number and a 2-bit external selector.

Between yields, execution is ordinary. Each instruction is one or two bytes long, and the length is decoded from the opcode. Call and jump stay inside the current 256-byte page. There is a one-entry return stack. Every instruction takes a fixed number of clock cycles. A debug view shows the program counter, the opcode being executed and a strobe in the cycle where the instruction commits.

Top module: `seqr_core`

## Requirements
- R1: While reset is high, and on the first cycle after it, the program counter reads 0 and the error flag is clear. Reset also sets the segment register to 0 and empties the return stack.
- R2: Every instruction takes exactly PHASES clock cycles (default 5). `dbg_step` is high for one cycle per instruction, and consecutive strobes are PHASES cycles apart.
- R3: The following opcodes are two bytes long and advance the PC by 2: 0x88–0x8F, 0xB8–0xBF, 0xF0–0xF7, 0xE0, 0xE8, 0xFC and 0xFE. The operand is the byte at PC+1. Every other opcode without a control effect advances the PC by 1.
- R4: 0xFC (call) saves PC+2 on the one-entry return stack, overwriting any earlier entry. It then loads the PC with the top 2 bits of the current PC followed by the operand byte.
- R5: 0xFD (return) with a saved entry loads that entry into the PC and empties the stack.
- R6: 0xFD with an empty stack sets `ret_err` and advances the PC by 1. `ret_err` stays set until reset.
- R7: 0xFE (jump) loads the PC with the top 2 bits of the current PC followed by the operand byte.
- R8: Opcodes 0x00–0x0F are one byte long. They store the low nibble as the next segment number and advance the PC by 1.
- R9: 0xEE (yield) loads the PC from the dispatch table. The key is {selector[1:0], routine[3:0], segment[3:0]}. Exact entries are: {0,1,0}→0x120, {0,1,3}→0x1A4, {0,2,5}→0x08C and {3,6,0}→0x33F.
- R10: Some entries match a set of segments. Selector 1, routine 3 sends segments 0 and 8 to 0x2B0, and segments 3 and 11 to 0x2C6. Selector 1, routine 1 sends segments 8–15 to 0x305. Selector 2 ignores the segment: routine 4 goes to 0x0D0 and routine 5 goes to 0x17A.
- R11: A yield whose key matches no entry loads PC 0.
- R12: Every PC produced by a yield is below 0x340.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | 10 | Code ROM read address |
| rom_data | input | 8 | Code ROM read data, combinational from rom_addr |
| routine_id | input | 4 | Routine number used in the dispatch key |
| sel_bits | input | 2 | Selector bits used in the dispatch key |
| dbg_pc | output | 10 | Current program counter |
| dbg_insn | output | 8 | Opcode of the instruction in progress |
| dbg_step | output | 1 | High in the commit cycle of each instruction |
| ret_err | output | 1 | Sticky flag: a return was executed with an empty stack |

## Verification
The hardest case to reach is a yield whose outcome depends on a segment number recorded several instructions earlier. It must also come after calls, returns and page-local jumps have already moved the PC across pages. The stimulus is one ROM program with a shared prefix: a call into a subroutine, a return from it, an empty-stack return, a jump, a segment declaration and then a yield. The code each dispatch target lands on declares a new segment and yields again. Several runs, each started from reset with a different selector and routine, then steer the same yield into an exact match, a segment set, a wildcard entry and a miss.

// File: rtl/seqr_pkg.sv
package seqr_pkg;
    localparam int unsigned PC_W   = 10;
    localparam int unsigned PAGE_W = 8;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ID_W   = 4;
    localparam int unsigned SEL_W  = 2;
    localparam int unsigned KEY_W  = SEL_W + 2 * ID_W;
    localparam int unsigned HI_W   = PC_W - PAGE_W;

    localparam logic [BYTE_W-1:0] OPC_YIELD = 8'hEE;
    localparam logic [BYTE_W-1:0] OPC_CALL  = 8'hFC;
    localparam logic [BYTE_W-1:0] OPC_RET   = 8'hFD;
    localparam logic [BYTE_W-1:0] OPC_JUMP  = 8'hFE;

    typedef enum logic [2:0] {
        K_PLAIN, K_SEG, K_YIELD, K_CALL, K_RET, K_JUMP
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     two_byte;
    } op_ctrl_t;

    function automatic logic is_two_byte(input logic [BYTE_W-1:0] op);
        return (op[7:3] == 5'b10001) || (op[7:3] == 5'b10111) ||
               (op[7:3] == 5'b11110) || (op == 8'hE0) || (op == 8'hE8) ||
               (op == OPC_CALL) || (op == OPC_JUMP);
    endfunction
endpackage

// File: rtl/seqr_decode.sv
module seqr_decode
    import seqr_pkg::*;
(
    input  logic [BYTE_W-1:0] opc,
    output op_ctrl_t          ctrl
);
    always_comb begin
        ctrl.two_byte = is_two_byte(opc);
        if (opc == OPC_YIELD)         ctrl.kind = K_YIELD;
        else if (opc == OPC_CALL)     ctrl.kind = K_CALL;
        else if (opc == OPC_RET)      ctrl.kind = K_RET;
        else if (opc == OPC_JUMP)     ctrl.kind = K_JUMP;
        else if (opc[7:4] == 4'h0)    ctrl.kind = K_SEG;
        else                          ctrl.kind = K_PLAIN;
    end
endmodule

// File: rtl/seqr_dispatch.sv
module seqr_dispatch
    import seqr_pkg::*;
(
    input  logic [KEY_W-1:0] key,
    output logic [PC_W-1:0]  target
);
    // key = {selector, routine, segment}; '?' bits are segment wildcards
    always_comb begin
        unique casez (key)
            10'b00_0001_0000: target = 10'h120;
            10'b00_0001_0011: target = 10'h1A4;
            10'b00_0010_0101: target = 10'h08C;
            10'b01_0011_?000: target = 10'h2B0;
            10'b01_0011_?011: target = 10'h2C6;
            10'b01_0001_1???: target = 10'h305;
            10'b10_0100_????: target = 10'h0D0;
            10'b10_0101_????: target = 10'h17A;
            10'b11_0110_0000: target = 10'h33F;
            default:          target = '0;
        endcase
    end
endmodule

// File: rtl/seqr_retstack.sv
module seqr_retstack
    import seqr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_addr,
    output logic            valid,
    output logic [PC_W-1:0] top_addr
);
    // single entry: a push overwrites, a pop empties
    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            top_addr <= '0;
        end else if (push) begin
            valid    <= 1'b1;
            top_addr <= push_addr;
        end else if (pop) begin
            valid    <= 1'b0;
        end
    end
endmodule

// File: rtl/seqr_core.sv
module seqr_core
    import seqr_pkg::*;
#(
    parameter int unsigned PHASES = 5
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   rom_addr,
    input  logic [BYTE_W-1:0] rom_data,
    input  logic [ID_W-1:0]   routine_id,
    input  logic [SEL_W-1:0]  sel_bits,
    output logic [PC_W-1:0]   dbg_pc,
    output logic [BYTE_W-1:0] dbg_insn,
    output logic              dbg_step,
    output logic              ret_err
);
    localparam int unsigned     PH_W    = (PHASES < 4) ? 2 : $clog2(PHASES);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    logic [PH_W-1:0]   ph;
    logic [PC_W-1:0]   pc, pc_nxt, pc_p1, pc_p2, page_tgt, disp_tgt, stk_addr;
    logic [BYTE_W-1:0] opc, opr;
    logic [ID_W-1:0]   seg;
    logic              err, commit, stk_valid;
    op_ctrl_t          ctrl;

    seqr_decode   dec_i (.opc(opc), .ctrl(ctrl));
    seqr_dispatch dsp_i (.key({sel_bits, routine_id, seg}), .target(disp_tgt));
    seqr_retstack stk_i (
        .clk(clk), .rst(rst),
        .push(commit && ctrl.kind == K_CALL),
        .pop(commit && ctrl.kind == K_RET),
        .push_addr(pc_p2),
        .valid(stk_valid), .top_addr(stk_addr)
    );

    assign commit   = (ph == PH_LAST);
    assign pc_p1    = pc + PC_W'(1);
    assign pc_p2    = pc + PC_W'(2);
    assign page_tgt = {pc[PC_W-1:PAGE_W], opr};
    assign rom_addr = (ph == '0) ? pc : pc_p1;

    always_comb begin
        unique case (ctrl.kind)
            K_CALL, K_JUMP: pc_nxt = page_tgt;
            K_RET:          pc_nxt = stk_valid ? stk_addr : pc_p1;
            K_YIELD:        pc_nxt = disp_tgt;
            default:        pc_nxt = ctrl.two_byte ? pc_p2 : pc_p1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= '0;
            pc  <= '0;
            opc <= '0;
            opr <= '0;
            seg <= '0;
            err <= 1'b0;
        end else begin
            ph <= commit ? '0 : ph + PH_W'(1);
            if (ph == PH_W'(0)) opc <= rom_data;
            if (ph == PH_W'(1)) opr <= rom_data;
            if (commit) begin
                pc <= pc_nxt;
                if (ctrl.kind == K_SEG) seg <= opc[ID_W-1:0];
                if (ctrl.kind == K_RET && !stk_valid) err <= 1'b1;
            end
        end
    end

    assign dbg_pc   = pc;
    assign dbg_insn = opc;
    assign dbg_step = commit;
    assign ret_err  = err;
endmodule

// File: rtl/seqr_core_chk.sv
module seqr_core_chk
    import seqr_pkg::*;
#(
    parameter int unsigned PHASES = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [PC_W-1:0]   dbg_pc,
    input logic [BYTE_W-1:0] dbg_insn,
    input logic              dbg_step,
    input logic              ret_err
);
    int unsigned gap;
    always_ff @(posedge clk) begin
        if (rst || dbg_step) gap <= 0;
        else                 gap <= gap + 1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (dbg_pc == '0 && !ret_err));

    p_step_gap_r2: assert property (@(posedge clk) disable iff (rst)
        dbg_step |-> gap == PHASES - 1);

    p_call_page_r4: assert property (@(posedge clk) disable iff (rst)
        (dbg_step && dbg_insn == OPC_CALL) |=> dbg_pc[PC_W-1:PAGE_W] == $past(dbg_pc[PC_W-1:PAGE_W]));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        ret_err |=> ret_err);

    p_jump_page_r7: assert property (@(posedge clk) disable iff (rst)
        (dbg_step && dbg_insn == OPC_JUMP) |=> dbg_pc[PC_W-1:PAGE_W] == $past(dbg_pc[PC_W-1:PAGE_W]));

    p_seg_decl_r8: assert property (@(posedge clk) disable iff (rst)
        (dbg_step && dbg_insn[7:4] == 4'h0) |=> dbg_pc == $past(dbg_pc) + PC_W'(1));

    p_disp_bound_r12: assert property (@(posedge clk) disable iff (rst)
        (dbg_step && dbg_insn == OPC_YIELD) |=> dbg_pc < 10'h340);
endmodule

bind seqr_core seqr_core_chk #(.PHASES(PHASES)) chk_i (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_insn(dbg_insn),
    .dbg_step(dbg_step), .ret_err(ret_err)
);

// File: tb/seqr_core_tb_top.sv
module seqr_core_tb_top;
    localparam int unsigned PHASES = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] rom_addr;
    logic [7:0] rom_data;
    logic [3:0] routine_id = '0;
    logic [1:0] sel_bits = '0;
    logic [9:0] dbg_pc;
    logic [7:0] dbg_insn;
    logic       dbg_step, ret_err;

    logic [7:0] rom_mem [0:1023];
    assign rom_data = rom_mem[rom_addr];

    always #10 clk = ~clk;

    seqr_core #(.PHASES(PHASES)) dut_i (
        .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
        .routine_id(routine_id), .sel_bits(sel_bits), .dbg_pc(dbg_pc),
        .dbg_insn(dbg_insn), .dbg_step(dbg_step), .ret_err(ret_err)
    );

    int unsigned nvec = 0, nbad = 0;
    logic [9:0]  exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [9:0] pcv, input string req);
        exp_q.push_back(pcv);
        tag_q.push_back(req);
    endtask

    // monitor: compare PC after every commit, and commit spacing
    bit cmp_due = 0;
    int cyc = 0, last_step = -1;
    always @(negedge clk) begin
        cyc++;
        if (cmp_due && exp_q.size() > 0) begin
            logic [9:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, dbg_pc, e);
        end
        if (rst) last_step = -1;
        else if (dbg_step) begin
            if (last_step >= 0) chk("R2 step spacing", cyc - last_step, PHASES);
            last_step = cyc;
        end
        cmp_due = dbg_step && !rst;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    task automatic push_prefix();
        push(10'h001, "R8 segment declaration");
        push(10'h002, "R3 one-byte advance");
        push(10'h004, "R3 two-byte advance");
        push(10'h040, "R4 call target");
        push(10'h042, "R3 two-byte in subroutine");
        push(10'h006, "R5 return to saved address");
        push(10'h007, "R6 empty return advances");
        push(10'h020, "R7 page jump");
        push(10'h021, "R8 segment declaration");
    endtask

    task automatic run(input logic [1:0] sv, input logic [3:0] rv);
        @(negedge clk);
        rst = 1'b1;
        sel_bits = sv;
        routine_id = rv;
        repeat (2) @(negedge clk);
        chk("R1 reset pc", dbg_pc, 0);
        chk("R1 reset err", ret_err, 0);
        rst = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        chk("R6 sticky error", ret_err, 1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) rom_mem[i] = 8'hFF;
        // shared prefix
        rom_mem[10'h000] = 8'h0D;
        rom_mem[10'h001] = 8'hA3;
        rom_mem[10'h002] = 8'h88; rom_mem[10'h003] = 8'h55;
        rom_mem[10'h004] = 8'hFC; rom_mem[10'h005] = 8'h40;
        rom_mem[10'h040] = 8'hF2; rom_mem[10'h041] = 8'h11;
        rom_mem[10'h042] = 8'hFD;
        rom_mem[10'h006] = 8'hFD;
        rom_mem[10'h007] = 8'hFE; rom_mem[10'h008] = 8'h20;
        rom_mem[10'h020] = 8'h03;
        rom_mem[10'h021] = 8'hEE;
        // exact-match landing
        rom_mem[10'h1A4] = 8'hE8; rom_mem[10'h1A5] = 8'h00;
        rom_mem[10'h1A6] = 8'hFC; rom_mem[10'h1A7] = 8'hF0;
        rom_mem[10'h1F0] = 8'hFE; rom_mem[10'h1F1] = 8'h10;
        rom_mem[10'h110] = 8'hFD;
        rom_mem[10'h1A8] = 8'h08;
        rom_mem[10'h1A9] = 8'hEE;
        // segment-set landing
        rom_mem[10'h2C6] = 8'h0B;
        rom_mem[10'h2C7] = 8'hEE;
        // wildcard landing
        rom_mem[10'h0D0] = 8'h0F;
        rom_mem[10'h0D1] = 8'hEE;

        // A: exact entry, page-1 call/jump/return, then a miss
        push_prefix();
        push(10'h1A4, "R9 exact dispatch");
        push(10'h1A6, "R3 0xE8 two-byte");
        push(10'h1F0, "R4 call keeps page 1");
        push(10'h110, "R7 jump keeps page 1");
        push(10'h1A8, "R5 return from page 1");
        push(10'h1A9, "R8 segment declaration");
        push(10'h000, "R11 unmatched key to 0");
        run(2'd0, 4'd1);

        // B: segment set {3,11}
        push_prefix();
        push(10'h2C6, "R10 set entry seg 3");
        push(10'h2C7, "R8 segment declaration");
        push(10'h2C6, "R10 set entry seg 11");
        run(2'd1, 4'd3);

        // C: wildcard on segment
        push_prefix();
        push(10'h0D0, "R10 wildcard seg 3");
        push(10'h0D1, "R8 segment declaration");
        push(10'h0D0, "R10 wildcard seg 15");
        run(2'd2, 4'd4);

        // D: selector 3 routine 6 only matches segment 0
        push_prefix();
        push(10'h000, "R11 miss R12 bound");
        run(2'd3, 4'd6);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule